// File: doc/BRIEF.md
# Snapshot Static Priority Arbiter

This arbiter separates request capture from the grant decision. While it is idle, any active request makes it freeze the whole request vector into a lock register. On the next cycle a purely combinational priority function chooses one winner from the frozen bits. The grant then stays with that winner until the winner lowers its request. After that the lock is released, and any requests still waiting are captured in a new snapshot.

The priority function comes from one configuration bit that is sampled only while reset is asserted. Linear mode favours the lowest-numbered client. Group mode splits the clients into fixed groups and favours the group with the most locked requests. A frozen request that is withdrawn before the decision counts as absent. If nothing is left to grant, the arbiter discards the snapshot and returns to capture, so it never stalls.

Top module: `snap_arb`

## Requirements
- R1: While `rst_ni` is low, and in the first cycle after it rises, `gnt_o` is all zero.
- R2: When the arbiter is idle and any bit of `req_i` is high at a rising clock edge, that vector is locked. The grant appears after the following rising edge, two edges after the capture edge counting that edge.
- R3: With mode 0 (linear), the lowest-numbered locked request wins. Bit 0 is client 1.
- R4: With mode 1 (group), bits 0–1 form group A and bits 2–3 form group B. The group with more locked active requests wins.
- R5: In group mode, equal counts go to group A. Inside the winning group, the lower bit index wins.
- R6: `gnt_o` is zero or one-hot. A grant holds its value for as long as the granted request stays high, whatever the other requests do.
- R7: When the granted request is low at a rising edge, `gnt_o` clears on that edge. No new grant can appear on the edge that follows.
- R8: A request that rises after the lock edge is not part of the current snapshot. It is served only by a later snapshot.
- R9: A locked request that is low at the decision edge is treated as absent. If no locked request remains, no grant is issued and capture restarts on the next edge.
- R10: `mode_i` is sampled only while `rst_ni` is low. Changes to `mode_i` after reset do not affect the grants.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 1 | Priority function select: 0 linear, 1 group; sampled during reset |
| req_i | input | NUM_REQ | Request per client, held high until served |
| gnt_o | output | NUM_REQ | One-hot grant, held while the winner requests |

## Verification
The bench uses the default build: four clients in two groups of two. This makes every group-count outcome reachable, including both tie cases, a strict majority for either group, and the single-request case in each group. With this small width, every request pattern the vector table covers can be checked by hand against both priority functions. Directed sequences cover late-rising requests, withdrawal before the decision with the restart that follows, a mode change after reset, and re-capture of pending requests once the winner releases.

// File: rtl/snap_arb_pkg.sv
package snap_arb_pkg;
  typedef enum logic {
    PRIO_LINEAR = 1'b0,
    PRIO_GROUP  = 1'b1
  } prio_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_DECIDE = 2'd1,
    ST_HOLD   = 2'd2
  } arb_state_e;
endpackage

// File: rtl/snap_lock_reg.sv
module snap_lock_reg #(
  parameter int unsigned NUM_REQ = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               capture_i,
  input  logic               clear_i,
  input  logic [NUM_REQ-1:0] req_i,
  output logic [NUM_REQ-1:0] lock_o
);
  logic [NUM_REQ-1:0] lock_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        lock_q <= '0;
    else if (clear_i)   lock_q <= '0;
    else if (capture_i) lock_q <= req_i;
  end

  assign lock_o = lock_q;
endmodule

// File: rtl/snap_prio_fn.sv
module snap_prio_fn
  import snap_arb_pkg::*;
#(
  parameter int unsigned NUM_REQ    = 4,
  parameter int unsigned GROUP_SIZE = 2
) (
  input  prio_mode_e         mode_i,
  input  logic [NUM_REQ-1:0] cand_i,
  output logic [NUM_REQ-1:0] pick_o
);
  localparam int unsigned NUM_GROUPS = NUM_REQ / GROUP_SIZE;
  localparam int unsigned CNT_W      = $clog2(GROUP_SIZE + 1);
  localparam int unsigned GID_W      = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1;

  logic [NUM_REQ-1:0]  lin_pick;
  logic [NUM_REQ-1:0]  grp_pick;
  logic [CNT_W-1:0]    grp_cnt [NUM_GROUPS];

  // lowest index first
  always_comb begin
    logic found;
    found    = 1'b0;
    lin_pick = '0;
    for (int i = 0; i < NUM_REQ; i++) begin
      if (cand_i[i] && !found) begin
        lin_pick[i] = 1'b1;
        found       = 1'b1;
      end
    end
  end

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_cnt
    always_comb begin
      grp_cnt[g] = '0;
      for (int k = 0; k < GROUP_SIZE; k++)
        grp_cnt[g] = grp_cnt[g] + CNT_W'(cand_i[g*GROUP_SIZE+k]);
    end
  end

  // largest count wins, strict compare keeps the lower group on ties
  always_comb begin
    logic [CNT_W-1:0] best_cnt;
    logic [GID_W-1:0] best_gid;
    logic             found;
    best_cnt = grp_cnt[0];
    best_gid = '0;
    for (int g = 1; g < NUM_GROUPS; g++) begin
      if (grp_cnt[g] > best_cnt) begin
        best_cnt = grp_cnt[g];
        best_gid = GID_W'(g);
      end
    end
    grp_pick = '0;
    found    = 1'b0;
    if (best_cnt != '0) begin
      for (int k = 0; k < GROUP_SIZE; k++) begin
        if (!found && cand_i[int'(best_gid)*GROUP_SIZE+k]) begin
          grp_pick[int'(best_gid)*GROUP_SIZE+k] = 1'b1;
          found = 1'b1;
        end
      end
    end
  end

  assign pick_o = (mode_i == PRIO_GROUP) ? grp_pick : lin_pick;
endmodule

// File: rtl/snap_arb_ctrl.sv
module snap_arb_ctrl
  import snap_arb_pkg::*;
#(
  parameter int unsigned NUM_REQ = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_REQ-1:0] req_i,
  input  logic [NUM_REQ-1:0] pick_i,
  output logic               capture_o,
  output logic               clear_o,
  output logic [NUM_REQ-1:0] gnt_o
);
  arb_state_e         state_q, state_d;
  logic [NUM_REQ-1:0] gnt_q, gnt_d;

  always_comb begin
    state_d   = state_q;
    gnt_d     = gnt_q;
    capture_o = 1'b0;
    clear_o   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (|req_i) begin
          capture_o = 1'b1;
          state_d   = ST_DECIDE;
        end
      end
      ST_DECIDE: begin
        if (pick_i == '0) begin
          // nil grant: drop snapshot, capture again
          clear_o = 1'b1;
          state_d = ST_IDLE;
        end else begin
          gnt_d   = pick_i;
          state_d = ST_HOLD;
        end
      end
      ST_HOLD: begin
        if (!(|(req_i & gnt_q))) begin
          clear_o = 1'b1;
          gnt_d   = '0;
          state_d = ST_IDLE;
        end
      end
      default: begin
        clear_o = 1'b1;
        gnt_d   = '0;
        state_d = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      gnt_q   <= '0;
    end else begin
      state_q <= state_d;
      gnt_q   <= gnt_d;
    end
  end

  assign gnt_o = gnt_q;
endmodule

// File: rtl/snap_arb.sv
module snap_arb
  import snap_arb_pkg::*;
#(
  parameter int unsigned NUM_REQ    = 4,
  parameter int unsigned GROUP_SIZE = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               mode_i,
  input  logic [NUM_REQ-1:0] req_i,
  output logic [NUM_REQ-1:0] gnt_o
);
  prio_mode_e         mode_q;
  logic [NUM_REQ-1:0] lock;
  logic [NUM_REQ-1:0] cand;
  logic [NUM_REQ-1:0] pick;
  logic               capture;
  logic               clear;

  // follows mode_i only while reset is held
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mode_q <= prio_mode_e'(mode_i);
    else         mode_q <= mode_q;
  end

  snap_lock_reg #(.NUM_REQ(NUM_REQ)) u_lock (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .capture_i (capture),
    .clear_i   (clear),
    .req_i     (req_i),
    .lock_o    (lock)
  );

  // withdrawn locked bits count as lost; late risers are masked by lock
  assign cand = lock & req_i;

  snap_prio_fn #(.NUM_REQ(NUM_REQ), .GROUP_SIZE(GROUP_SIZE)) u_prio (
    .mode_i (mode_q),
    .cand_i (cand),
    .pick_o (pick)
  );

  snap_arb_ctrl #(.NUM_REQ(NUM_REQ)) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_i     (req_i),
    .pick_i    (pick),
    .capture_o (capture),
    .clear_o   (clear),
    .gnt_o     (gnt_o)
  );
endmodule

// File: rtl/snap_arb_chk.sv
module snap_arb_chk
  import snap_arb_pkg::*;
#(
  parameter int unsigned NUM_REQ = 4
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [NUM_REQ-1:0] req_i,
  input logic [NUM_REQ-1:0] gnt_o,
  input prio_mode_e         mode_q
);
  a_r6_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_o));

  a_r6_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((gnt_o != '0) && ((req_i & gnt_o) != '0)) |=> (gnt_o == $past(gnt_o)));

  a_r7_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((gnt_o != '0) && ((req_i & gnt_o) == '0)) |=> (gnt_o == '0));

  a_r7_no_regrant: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (($past(gnt_o) != '0) && (gnt_o == '0)) |=> (gnt_o == '0));

  a_r9_winner_present: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (($past(gnt_o) == '0) && (gnt_o != '0)) |-> ((gnt_o & $past(req_i)) != '0));

  a_r10_mode_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $stable(mode_q));
endmodule

bind snap_arb snap_arb_chk #(.NUM_REQ(NUM_REQ)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .req_i  (req_i),
  .gnt_o  (gnt_o),
  .mode_q (mode_q)
);

// File: tb/sim_snap_arb.sv
`timescale 1ns/1ps
module sim_snap_arb;
  localparam int unsigned N = 4;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         mode_i = 1'b0;
  logic [N-1:0] req_i = '0;
  logic [N-1:0] gnt_o;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #4 clk_i = ~clk_i;

  snap_arb #(.NUM_REQ(N), .GROUP_SIZE(2)) u0 (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .mode_i (mode_i),
    .req_i  (req_i),
    .gnt_o  (gnt_o)
  );

  // {mode, req, expected grant}
  localparam int NV = 13;
  localparam logic [8:0] VEC [NV] = '{
    {1'b0, 4'b0001, 4'b0001},
    {1'b0, 4'b0110, 4'b0010},
    {1'b0, 4'b1000, 4'b1000},
    {1'b0, 4'b1100, 4'b0100},
    {1'b0, 4'b1111, 4'b0001},
    {1'b1, 4'b1100, 4'b0100},
    {1'b1, 4'b0111, 4'b0001},
    {1'b1, 4'b1101, 4'b0100},
    {1'b1, 4'b0101, 4'b0001},
    {1'b1, 4'b1000, 4'b1000},
    {1'b1, 4'b1010, 4'b0010},
    {1'b1, 4'b1110, 4'b0100},
    {1'b1, 4'b1111, 4'b0001}
  };

  task automatic step(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic check(input string req, input logic [N-1:0] exp);
    n_run++;
    if (gnt_o !== exp) begin
      n_fail++;
      $display("FAIL %s: gnt_o=%b expected=%b", req, gnt_o, exp);
    end
  endtask

  task automatic do_reset(input logic m);
    rst_ni = 1'b0;
    mode_i = m;
    req_i  = '0;
    step(2);
    rst_ni = 1'b1;
    step(1);
  endtask

  initial begin
    logic cur_mode;
    step(1);
    do_reset(1'b0);
    cur_mode = 1'b0;
    check("R1 reset", 4'b0000);

    // table walk: R3 linear, R4/R5 group, R2 latency, R7 release
    for (int v = 0; v < NV; v++) begin
      if (VEC[v][8] != cur_mode) begin
        do_reset(VEC[v][8]);
        cur_mode = VEC[v][8];
      end
      req_i = VEC[v][7:4];
      step(2);
      check(VEC[v][8] ? "R4 R5 group pick" : "R3 linear pick", VEC[v][3:0]);
      req_i = '0;
      step(1);
      check("R7 clear after drop", 4'b0000);
      step(1);
    end

    // R10: mode change after reset has no effect
    do_reset(1'b0);
    mode_i = 1'b1;
    req_i  = 4'b1101;
    step(2);
    check("R10 mode frozen", 4'b0001);
    req_i = '0;
    step(2);

    // R2: no grant after only the capture edge
    req_i = 4'b0010;
    step(1);
    check("R2 not yet granted", 4'b0000);
    step(1);
    check("R2 granted", 4'b0010);
    // R6: others change, winner holds
    req_i = 4'b1011;
    step(3);
    check("R6 hold", 4'b0010);
    // R7: release, then re-capture of pending bit0/bit3
    req_i = 4'b1001;
    step(1);
    check("R7 cleared", 4'b0000);
    step(1);
    check("R7 no regrant on next edge", 4'b0000);
    step(1);
    check("R7 new snapshot", 4'b0001);
    req_i = '0;
    step(2);

    // R8: late riser excluded from the snapshot
    req_i = 4'b0100;
    step(1);
    req_i = 4'b0101;
    step(1);
    check("R8 late riser excluded", 4'b0100);
    req_i = 4'b0001;
    step(1);
    check("R8 released", 4'b0000);
    step(2);
    check("R8 served next snapshot", 4'b0001);
    req_i = '0;
    step(2);

    // R9: withdrawn locked bit treated as absent
    req_i = 4'b0011;
    step(1);
    req_i = 4'b0010;
    step(1);
    check("R9 withdrawn bit lost", 4'b0010);
    req_i = '0;
    step(2);

    // R9: all locked bits withdrawn -> nil, restart
    req_i = 4'b0100;
    step(1);
    req_i = 4'b0000;
    step(1);
    check("R9 nil no grant", 4'b0000);
    req_i = 4'b1000;
    step(2);
    check("R9 restart after nil", 4'b1000);
    req_i = '0;
    step(2);

    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      done = 1'b1;
      n_run++;
      n_fail++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule